// File: doc/BRIEF.md
# Time-Shared Multichannel Equalizing FIR

This block equalizes nine sample streams with one ten-tap FIR filter datapath. Eight main tracks (indices 0 to 7) all filter with one shared set of coefficients. A ninth, auxiliary channel (index 8) filters with a separate coefficient set. Samples arrive one at a time on a strobe that carries a channel index and an 8-bit two's-complement value. Each accepted sample is staged for its channel and marks that channel as pending.

A sequencer serves pending channels one at a time. It always takes the lowest pending index first. For the chosen channel it shifts the staged sample into that channel's ten-deep history. A single multiply-accumulate unit then forms the ten-product sum over ten clock cycles, in a 20-bit signed accumulator.

A two-bit scale code selects an arithmetic right shift of the sum. The low eight bits of the shifted value are presented as the result, so large sums wrap around instead of clamping. Each result appears with a one-cycle valid pulse and the index of the channel it belongs to. Coefficients are supplied as static flat vectors by surrounding logic.

Top module: `trackeq`

## Requirements
- R1: After synchronous reset, out_valid, out_chan and out_data are 0, and every channel's sample history reads as all zeros.
- R2: For a main channel c (0 to 7), the result is the sum over taps k = 0 to 9 of coef_main[8k+7:8k] multiplied by the sample of channel c taken k samples earlier (k = 0 is the newest sample). Samples and coefficients are signed, and each channel keeps its own history.
- R3: For channel 8, the auxiliary channel, the same sum is formed with coef_aux[8k+7:8k] in place of the main coefficients.
- R4: scale_sel values 0, 1, 2 and 3 shift the 20-bit sum arithmetically right by 0, 1, 2 and 3 bits. out_data is the low 8 bits of the shifted value, so the result wraps modulo 256 and does not saturate.
- R5: When several channels are pending as the datapath becomes free, their results are produced in ascending channel order. out_chan is always within 0 to 8 while out_valid is high.
- R6: out_valid is a single-cycle pulse, and two pulses are always at least 12 clock cycles apart.
- R7: A sample strobe that arrives while nothing is pending or in progress produces its out_valid pulse in the 12th cycle after the edge that takes the strobe.
- R8: Strobes whose smp_chan is 9 to 15 are ignored. They produce no result and leave every channel's history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 4 | Channel index of the strobed sample (0-7 main, 8 auxiliary) |
| smp_data | input | 8 | Signed sample value |
| coef_main | input | 80 | Shared main-track taps, tap k in bits [8k+7:8k] |
| coef_aux | input | 80 | Auxiliary-channel taps, tap k in bits [8k+7:8k] |
| scale_sel | input | 2 | Right-shift code applied before the 8-bit wrap |
| out_valid | output | 1 | One-cycle result strobe |
| out_chan | output | 4 | Channel index of the result |
| out_data | output | 8 | Scaled and wrapped result |

## Verification
The hardest situation to reach from the ports is arbitration among many pending channels that arrived in an order different from the service order. The stimulus first strobes one channel so that the datapath is busy. During that job it strobes the remaining eight channels in descending index order. The bench then expects the first channel, followed by the others in ascending order. This is swept over every scale code and over coefficient sets that include full-scale negative taps, so that the wrap is exercised, and it is repeated after a mid-run reset and after strobes carrying out-of-range indices.

// File: rtl/trackeq_pkg.sv
package trackeq_pkg;

    localparam int NMAIN_DEF = 8;
    localparam int NTAP_DEF  = 10;
    localparam int DW_DEF    = 8;
    localparam int ACCW_DEF  = 20;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_MAC  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/trackeq_seq.sv
module trackeq_seq
    import trackeq_pkg::*;
#(
    parameter int NCHAN = 9,
    parameter int NTAP  = 10,
    localparam int CHW  = $clog2(NCHAN),
    localparam int TAPW = $clog2(NTAP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [CHW-1:0]   smp_chan,
    output logic             load,
    output logic             mac_en,
    output logic             mac_first,
    output logic             mac_last,
    output logic [CHW-1:0]   cur_ch,
    output logic [TAPW-1:0]  cur_tap,
    output logic [NCHAN-1:0] pend
);

    seq_state_e       st_q;
    logic [NCHAN-1:0] pend_q;
    logic [NCHAN-1:0] set_v;
    logic [NCHAN-1:0] clr_v;
    logic [CHW-1:0]   ch_q;
    logic [CHW-1:0]   pick;
    logic [TAPW-1:0]  tap_q;
    logic             in_range;

    assign in_range = {1'b0, smp_chan} < (CHW+1)'(NCHAN);
    assign set_v    = (smp_valid && in_range) ? (NCHAN'(1) << smp_chan) : '0;
    assign clr_v    = (st_q == ST_LOAD) ? (NCHAN'(1) << ch_q) : '0;

    // lowest pending index wins
    always_comb begin
        pick = '0;
        for (int i = NCHAN - 1; i >= 0; i--) begin
            if (pend_q[i]) pick = CHW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_v) | set_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ch_q  <= '0;
            tap_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (|pend_q) begin
                        ch_q <= pick;
                        st_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    tap_q <= '0;
                    st_q  <= ST_MAC;
                end
                ST_MAC: begin
                    tap_q <= tap_q + 1'b1;
                    if (tap_q == TAPW'(NTAP - 1)) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign load      = (st_q == ST_LOAD);
    assign mac_en    = (st_q == ST_MAC);
    assign mac_first = (tap_q == '0);
    assign mac_last  = (tap_q == TAPW'(NTAP - 1));
    assign cur_ch    = ch_q;
    assign cur_tap   = tap_q;
    assign pend      = pend_q;

endmodule

// File: rtl/trackeq_lines.sv
module trackeq_lines #(
    parameter int NCHAN = 9,
    parameter int NTAP  = 10,
    parameter int DW    = 8,
    localparam int CHW  = $clog2(NCHAN),
    localparam int TAPW = $clog2(NTAP)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CHW-1:0]       wr_chan,
    input  logic signed [DW-1:0] wr_data,
    input  logic                 load,
    input  logic [CHW-1:0]       ch,
    input  logic [TAPW-1:0]      tap,
    output logic signed [DW-1:0] rd_x
);

    logic [NTAP*DW-1:0] hist_flat [NCHAN];

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic [DW-1:0]      stage_q;
        logic [NTAP*DW-1:0] line_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
            end else if (wr_en && wr_chan == CHW'(c)) begin
                stage_q <= wr_data;
            end
        end

        // newest sample sits in tap 0
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q <= '0;
            end else if (load && ch == CHW'(c)) begin
                line_q <= {line_q[(NTAP-1)*DW-1:0], stage_q};
            end
        end

        assign hist_flat[c] = line_q;
    end

    assign rd_x = hist_flat[ch][tap*DW +: DW];

endmodule

// File: rtl/trackeq_mac.sv
module trackeq_mac #(
    parameter int NMAIN = 8,
    parameter int NTAP  = 10,
    parameter int DW    = 8,
    parameter int ACCW  = 20,
    localparam int CHW  = $clog2(NMAIN + 1),
    localparam int TAPW = $clog2(NTAP),
    localparam int PW   = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 first,
    input  logic                 last,
    input  logic [CHW-1:0]       ch,
    input  logic [TAPW-1:0]      tap,
    input  logic signed [DW-1:0] x,
    input  logic [NTAP*DW-1:0]   coef_main,
    input  logic [NTAP*DW-1:0]   coef_aux,
    input  logic [1:0]           scale_sel,
    output logic                 out_valid,
    output logic [CHW-1:0]       out_chan,
    output logic [DW-1:0]        out_data
);

    logic signed [DW-1:0]   c_sel;
    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] prod_ext;
    logic signed [ACCW-1:0] acc_q;
    logic signed [ACCW-1:0] acc_base;
    logic signed [ACCW-1:0] acc_nx;
    logic signed [ACCW-1:0] scaled;
    logic                   is_aux;

    assign is_aux   = (ch == CHW'(NMAIN));
    assign c_sel    = is_aux ? coef_aux[tap*DW +: DW] : coef_main[tap*DW +: DW];
    assign prod     = x * c_sel;
    assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};
    assign acc_base = first ? '0 : acc_q;
    assign acc_nx   = acc_base + prod_ext;
    assign scaled   = acc_nx >>> scale_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= en && last;
            if (en && last) begin
                out_chan <= ch;
                out_data <= DW'(scaled);
            end
        end
    end

endmodule

// File: rtl/trackeq.sv
module trackeq
    import trackeq_pkg::*;
#(
    parameter int NMAIN = NMAIN_DEF,
    parameter int NTAP  = NTAP_DEF,
    parameter int DW    = DW_DEF,
    parameter int ACCW  = ACCW_DEF,
    localparam int NCHAN = NMAIN + 1,
    localparam int CHW   = $clog2(NCHAN),
    localparam int TAPW  = $clog2(NTAP)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic [CHW-1:0]       smp_chan,
    input  logic [DW-1:0]        smp_data,
    input  logic [NTAP*DW-1:0]   coef_main,
    input  logic [NTAP*DW-1:0]   coef_aux,
    input  logic [1:0]           scale_sel,
    output logic                 out_valid,
    output logic [CHW-1:0]       out_chan,
    output logic [DW-1:0]        out_data
);

    logic                 load_w;
    logic                 mac_en_w;
    logic                 mac_first_w;
    logic                 mac_last_w;
    logic [CHW-1:0]       ch_w;
    logic [TAPW-1:0]      tap_w;
    logic [NCHAN-1:0]     pend_w;
    logic signed [DW-1:0] x_w;

    trackeq_seq #(
        .NCHAN (NCHAN),
        .NTAP  (NTAP)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_chan  (smp_chan),
        .load      (load_w),
        .mac_en    (mac_en_w),
        .mac_first (mac_first_w),
        .mac_last  (mac_last_w),
        .cur_ch    (ch_w),
        .cur_tap   (tap_w),
        .pend      (pend_w)
    );

    trackeq_lines #(
        .NCHAN (NCHAN),
        .NTAP  (NTAP),
        .DW    (DW)
    ) u_lines (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (smp_valid),
        .wr_chan (smp_chan),
        .wr_data (smp_data),
        .load    (load_w),
        .ch      (ch_w),
        .tap     (tap_w),
        .rd_x    (x_w)
    );

    trackeq_mac #(
        .NMAIN (NMAIN),
        .NTAP  (NTAP),
        .DW    (DW),
        .ACCW  (ACCW)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .en        (mac_en_w),
        .first     (mac_first_w),
        .last      (mac_last_w),
        .ch        (ch_w),
        .tap       (tap_w),
        .x         (x_w),
        .coef_main (coef_main),
        .coef_aux  (coef_aux),
        .scale_sel (scale_sel),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_data  (out_data)
    );

endmodule

// File: rtl/trackeq_chk.sv
module trackeq_chk #(
    parameter int NCHAN = 9,
    parameter int NTAP  = 10,
    localparam int CHW  = $clog2(NCHAN)
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic [CHW-1:0]   smp_chan,
    input logic             out_valid,
    input logic [CHW-1:0]   out_chan,
    input logic [NCHAN-1:0] pend_bits
);

    logic [7:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (out_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R6
    pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen_q) |-> (gap_q >= 8'(NTAP + 1)));

    // R5
    chan_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({1'b0, out_chan} < (CHW+1)'(NCHAN)));

    // R8
    ignore_index_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && ({1'b0, smp_chan} >= (CHW+1)'(NCHAN)) && pend_bits == '0)
        |=> (pend_bits == '0));

endmodule

bind trackeq trackeq_chk #(
    .NCHAN (NCHAN),
    .NTAP  (NTAP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_chan  (smp_chan),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .pend_bits (pend_w)
);

// File: tb/trackeq_tb.sv
module trackeq_tb;

    localparam int NCH  = 9;
    localparam int NTAP = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [3:0]  smp_chan = '0;
    logic [7:0]  smp_data = '0;
    logic [79:0] coef_main = '0;
    logic [79:0] coef_aux = '0;
    logic [1:0]  scale_sel = '0;
    logic        out_valid;
    logic [3:0]  out_chan;
    logic [7:0]  out_data;

    always #10 clk = ~clk;

    trackeq u_dut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_chan  (smp_chan),
        .smp_data  (smp_data),
        .coef_main (coef_main),
        .coef_aux  (coef_aux),
        .scale_sel (scale_sel),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_data  (out_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int hist [NCH][NTAP];
    int cm [NTAP];
    int ca [NTAP];
    int exp_val [NCH];
    int exp_order [NCH];
    int scale = 0;

    task automatic check(string req, bit ok, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_model();
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < NTAP; k++) hist[c][k] = 0;
    endtask

    task automatic apply_coefs();
        for (int k = 0; k < NTAP; k++) begin
            coef_main[k*8 +: 8] = 8'(cm[k]);
            coef_aux[k*8 +: 8]  = 8'(ca[k]);
        end
        scale_sel = 2'(scale);
    endtask

    task automatic model_push(int c, int v);
        int sum;
        for (int k = NTAP - 1; k > 0; k--) hist[c][k] = hist[c][k-1];
        hist[c][0] = v;
        sum = 0;
        for (int k = 0; k < NTAP; k++)
            sum += ((c == NCH - 1) ? ca[k] : cm[k]) * hist[c][k];
        exp_val[c] = (sum >>> scale) & 255;
    endtask

    // called at a falling edge; holds the strobe for one cycle
    task automatic send(int c, int v);
        smp_chan  = 4'(c);
        smp_data  = 8'(v);
        smp_valid = 1'b1;
        if (c < NCH) model_push(c, v);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    function automatic int gen(int f, int c);
        return ((f * 73 + c * 29 + 11) % 256) - 128;
    endfunction

    task automatic run_frame(int f, int first, bit extreme, string tag);
        int got;
        int idx;
        string req;
        exp_order[0] = first;
        idx = 1;
        for (int c = 0; c < NCH; c++)
            if (c != first) begin
                exp_order[idx] = c;
                idx++;
            end
        send(first, extreme ? -128 : gen(f, first));
        for (int c = NCH - 1; c >= 0; c--)
            if (c != first) send(c, extreme ? -128 : gen(f, c));
        got = 0;
        for (int t = 0; t < 400 && got < NCH; t++) begin
            @(negedge clk);
            if (out_valid) begin
                check("R5", int'(out_chan) == exp_order[got], int'(out_chan), exp_order[got]);
                if (tag != "") req = tag;
                else if (scale != 0) req = "R4";
                else if (int'(out_chan) == NCH - 1) req = "R3";
                else req = "R2";
                if (int'(out_chan) < NCH)
                    check(req, int'(out_data) == exp_val[out_chan], int'(out_data), exp_val[out_chan]);
                got++;
            end
        end
        check("R5", got == NCH, got, NCH);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_model();
        // R1: outputs idle after reset
        check("R1", out_valid == 1'b0, int'(out_valid), 0);
        check("R1", out_chan == 4'd0, int'(out_chan), 0);
        check("R1", out_data == 8'd0, int'(out_data), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat;
        bit seen;
        bit stray;
        for (int k = 0; k < NTAP; k++) begin
            cm[k] = (k * 37 + 5) % 256 - 128;
            ca[k] = (k * 53 + 90) % 256 - 128;
        end
        scale = 0;
        apply_coefs();
        @(negedge clk);
        do_reset();

        // R7: latency from an idle block, first result after reset (R1 history cleared)
        send(3, 100);
        lat = 0;
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            lat++;
            if (out_valid) seen = 1'b1;
        end
        check("R7", seen && lat == 12, lat, 12);
        check("R1", int'(out_data) == exp_val[3], int'(out_data), exp_val[3]);

        // sweep: scale codes x coefficient sets x frames
        for (int s = 0; s < 4; s++) begin
            for (int cs = 0; cs < 3; cs++) begin
                scale = s;
                for (int k = 0; k < NTAP; k++) begin
                    if (cs == 0) begin
                        cm[k] = (k * 37 + 5) % 256 - 128;
                        ca[k] = (k * 53 + 90) % 256 - 128;
                    end else if (cs == 1) begin
                        cm[k] = (k == s + 2) ? 127 : 0;
                        ca[k] = (k == 9 - s) ? -128 : 1;
                    end else begin
                        cm[k] = -128;
                        ca[k] = 127;
                    end
                end
                apply_coefs();
                for (int f = 0; f < 4; f++)
                    run_frame(f + s * 16 + cs * 4, (f * 5 + cs + s) % NCH, (cs == 2 && f < 3), "");
            end
        end

        // R8: out-of-range indices produce nothing and disturb no history
        stray = 1'b0;
        for (int c = NCH; c < 16; c++) send(c, 77);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (out_valid) stray = 1'b1;
        end
        check("R8", stray == 1'b0, int'(stray), 0);
        run_frame(200, 8, 1'b0, "R8");

        // R1: reset in mid-run clears histories
        do_reset();
        scale = 1;
        apply_coefs();
        run_frame(300, 0, 1'b0, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule